// File: doc/BRIEF.md
# Card Data Byte FIFO Engine

This block sits between a processor register port and a byte-wide card data stream during block transfers. It keeps two 32-byte rings: one for bytes heading to the card and one for bytes arriving from it. A processor access moves 1, 2 or 4 bytes at a time, and the first byte in the stream always sits in the highest lane of the access. The engine counts the bytes still owed in the current transfer and raises a service request when the processor must act. When the count runs out, it sets the completion flags.

A transfer begins with a one-cycle `start` pulse. That pulse captures the direction, loads block length times block count as the byte total and empties both rings. On the card side a valid/ready handshake moves at most one byte per clock. An `abort` pulse ends a transfer without setting the completion flags. A partial-buffer write with bit 0 set throws away whatever the transmit ring holds.

Top module: `card_fifo_engine`

## Requirements
- R1: Each ring holds at most 32 bytes and its indices wrap modulo 32. A processor write is accepted only up to the free space measured before that cycle, and the bytes beyond it are dropped. `txLevel` and `rxLevel` report the occupancy.
- R2: A `start` pulse without `abort` makes the transfer active with a byte total of `blkLen * blkCnt`. It captures `dirWrite` (1 = toward the card), empties both rings and clears both status flags.
- R3: A processor write with `cpuBytes` = N (1 to 4; values above 4 act as 4, and 0 moves nothing) enqueues `cpuTxData[8N-1:8N-8]` first and then the lower lanes in turn. `txByte` shows the oldest byte in the ring.
- R4: A processor read with N bytes returns, in `cpuRxData` one clock later, the oldest byte in lane N-1 and the next bytes in the lanes below it. Lanes that the ring could not fill read as zero, and so do all lanes at N and above. The value then holds until the next read.
- R5: `txReq` is set on the clock after a cycle in which a write transfer is active, bytes are still owed and the transmit ring is empty. A processor write clears it, and the clear takes priority over the set.
- R6: `rxReq` is set by every byte accepted from the card. A processor read clears it, but an arriving byte in the same cycle wins over the clear.
- R7: In a write transfer, `txValid` is high exactly when the transfer is active, bytes are owed and the transmit ring is non-empty. Each handshake removes one byte from the ring and lowers `bytesLeft` by one.
- R8: In a read transfer, `rxReady` is high exactly when the transfer is active, bytes are owed and the receive ring holds fewer than 32 bytes. Each handshake appends `rxByte` to the ring and lowers `bytesLeft` by one.
- R9: The handshake that moves the last owed byte ends the transfer. On the next clock `active` is low and both the data-done status and the data-done interrupt flags are set. A write transfer also sets both programming-done flags. A start with a zero total completes in the same way on the next clock.
- R10: `partWr` with `partData[0]` = 1 empties the transmit ring and discards any bytes written in the same cycle. With bit 0 = 0 it changes nothing.
- R11: `abort` makes the transfer inactive on the next clock and sets no completion flag. A `start` in the same cycle is ignored.
- R12: `irqAck[0]` clears the data-done interrupt flag and `irqAck[1]` clears the programming-done interrupt flag. A completion in the same cycle wins over the acknowledge.
- R13: After reset the engine is idle. Both rings are empty, and all requests, flags, `bytesLeft` and `cpuRxData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer |
| abort | input | 1 | End the active transfer without completion |
| dirWrite | input | 1 | Direction captured at start, 1 = toward the card |
| blkLen | input | 12 | Bytes per block |
| blkCnt | input | 16 | Number of blocks |
| cpuTxWr | input | 1 | Processor write to the transmit port |
| cpuTxData | input | 32 | Write data, first byte in the highest used lane |
| cpuRxRd | input | 1 | Processor read from the receive port |
| cpuBytes | input | 3 | Access size in bytes |
| cpuRxData | output | 32 | Data of the latest receive read |
| partWr | input | 1 | Partial-buffer command write |
| partData | input | 32 | Partial-buffer command data, bit 0 flushes |
| irqAck | input | 2 | Clear data-done (bit 0) / programming-done (bit 1) interrupt |
| txByte | output | 8 | Byte offered to the card |
| txValid | output | 1 | `txByte` is valid |
| txReady | input | 1 | Card takes `txByte` |
| rxByte | input | 8 | Byte from the card |
| rxValid | input | 1 | `rxByte` is valid |
| rxReady | output | 1 | Engine can take `rxByte` |
| active | output | 1 | Transfer in progress |
| bytesLeft | output | 28 | Bytes still owed |
| txLevel | output | 6 | Transmit ring occupancy |
| rxLevel | output | 6 | Receive ring occupancy |
| txReq | output | 1 | Transmit service request |
| rxReq | output | 1 | Receive service request |
| statDataDone | output | 1 | Data-done status |
| statProgDone | output | 1 | Programming-done status |
| irqDataDone | output | 1 | Data-done interrupt flag |
| irqProgDone | output | 1 | Programming-done interrupt flag |

## Verification
The checks that run on every cycle cover the following properties:
- Ring occupancy never exceeds 32.
- Nothing is removed from an empty ring.
- A flush leaves the transmit ring empty.
- Each card handshake lowers the byte count by exactly one.
- A processor write always drops the transmit request.
- An abort leaves the done status untouched.
- Any other fall of `active` comes with data-done.

Only the bench scenarios can show the things that depend on contents and ordering: the lane order of packed and unpacked bytes, the zero fill of a read from a short ring, and the drop of bytes past a full ring. They also cover the interplay of requests with processor accesses, the zero-length start and acknowledge priority. The bench checks all of these against a queue-based model on every clock.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  typedef struct packed {
    logic txPop;
    logic rxPush;
    logic ringClear;
  } cfeStrobe_t;
endpackage

// File: rtl/cfe_datapath.sv
module cfe_datapath
  import cfe_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int BUS_BYTES = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1,
  localparam int NB_W  = $clog2(BUS_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cfeStrobe_t             st,
  input  logic                   flushReq,
  input  logic                   cpuTxWr,
  input  logic [8*BUS_BYTES-1:0] cpuTxData,
  input  logic                   cpuRxRd,
  input  logic [NB_W-1:0]        cpuBytes,
  input  logic [7:0]             rxByte,
  output logic [8*BUS_BYTES-1:0] cpuRxData,
  output logic [7:0]             txHead,
  output logic [LVL_W-1:0]       txCount,
  output logic [LVL_W-1:0]       rxCount
);
  logic [7:0] txMem [DEPTH];
  logic [7:0] rxMem [DEPTH];
  logic [PTR_W-1:0] txWr, txRd, rxWr, rxRd;
  logic [NB_W-1:0]  reqN;
  logic [LVL_W-1:0] reqLvl, txFree, txAcc, rxTake;
  logic [LVL_W-1:0] popLvl, pushLvl;
  logic [8*BUS_BYTES-1:0] rdWord;

  always_comb begin
    reqN    = (cpuBytes > NB_W'(BUS_BYTES)) ? NB_W'(BUS_BYTES) : cpuBytes;
    reqLvl  = LVL_W'(reqN);
    txFree  = LVL_W'(DEPTH) - txCount;
    txAcc   = cpuTxWr ? ((reqLvl < txFree) ? reqLvl : txFree) : '0;
    rxTake  = cpuRxRd ? ((reqLvl < rxCount) ? reqLvl : rxCount) : '0;
    popLvl  = LVL_W'(st.txPop);
    pushLvl = LVL_W'(st.rxPush);
    txHead  = txMem[txRd];
  end

  // unpack: oldest byte lands in the highest used lane
  always_comb begin
    rdWord = '0;
    for (int i = 0; i < BUS_BYTES; i++) begin
      if (LVL_W'(i) < rxTake)
        rdWord[8*(int'(reqN)-1-i) +: 8] = rxMem[rxRd + PTR_W'(i)];
    end
  end

  // storage, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < BUS_BYTES; i++) begin
      if (LVL_W'(i) < txAcc)
        txMem[txWr + PTR_W'(i)] <= cpuTxData[8*(int'(reqN)-1-i) +: 8];
    end
    if (st.rxPush) rxMem[rxWr] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWr <= '0; txRd <= '0; txCount <= '0;
      rxWr <= '0; rxRd <= '0; rxCount <= '0;
      cpuRxData <= '0;
    end else begin
      if (cpuRxRd) cpuRxData <= rdWord;
      if (st.ringClear) begin
        txWr <= '0; txRd <= '0; txCount <= '0;
        rxWr <= '0; rxRd <= '0; rxCount <= '0;
      end else begin
        if (flushReq) begin
          txRd    <= txWr;
          txCount <= '0;
        end else begin
          txWr    <= txWr + PTR_W'(txAcc);
          txRd    <= txRd + PTR_W'(popLvl);
          txCount <= txCount + txAcc - popLvl;
        end
        rxWr    <= rxWr + PTR_W'(pushLvl);
        rxRd    <= rxRd + PTR_W'(rxTake);
        rxCount <= rxCount + pushLvl - rxTake;
      end
    end
  end

  assert_tx_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= LVL_W'(DEPTH));
  assert_rx_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= LVL_W'(DEPTH));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.txPop |-> txCount != '0);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.rxPush |-> rxCount != LVL_W'(DEPTH));
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && !st.ringClear) |=> txCount == '0);
endmodule

// File: rtl/cfe_ctrl.sv
module cfe_ctrl
  import cfe_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16,
  localparam int LVL_W  = $clog2(DEPTH) + 1,
  localparam int LEFT_W = LEN_W + CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              abort,
  input  logic              dirWrite,
  input  logic [LEN_W-1:0]  blkLen,
  input  logic [CNT_W-1:0]  blkCnt,
  input  logic              cpuTxWr,
  input  logic              cpuRxRd,
  input  logic [1:0]        irqAck,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [LVL_W-1:0]  txCount,
  input  logic [LVL_W-1:0]  rxCount,
  output cfeStrobe_t        st,
  output logic              txValid,
  output logic              rxReady,
  output logic              active,
  output logic [LEFT_W-1:0] bytesLeft,
  output logic              txReq,
  output logic              rxReq,
  output logic              statDataDone,
  output logic              statProgDone,
  output logic              irqDataDone,
  output logic              irqProgDone
);
  logic dirQ, owe, txFire, rxFire, begin_, lastByte, finishNow, finishDir;
  logic [LEFT_W-1:0] lenProd;

  always_comb begin
    owe       = bytesLeft != '0;
    txValid   = active & dirQ & owe & (txCount != '0);
    rxReady   = active & ~dirQ & owe & (rxCount != LVL_W'(DEPTH));
    txFire    = txValid & txReady;
    rxFire    = rxReady & rxValid;
    begin_    = start & ~abort;
    lenProd   = LEFT_W'(blkLen) * LEFT_W'(blkCnt);
    lastByte  = (txFire | rxFire) & (bytesLeft == LEFT_W'(1));
    finishNow = ~abort & (start ? (lenProd == '0) : lastByte);
    finishDir = start ? dirWrite : dirQ;
    st.txPop     = txFire;
    st.rxPush    = rxFire;
    st.ringClear = begin_;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0; dirQ <= 1'b0; bytesLeft <= '0;
      txReq <= 1'b0; rxReq <= 1'b0;
      statDataDone <= 1'b0; statProgDone <= 1'b0;
      irqDataDone <= 1'b0; irqProgDone <= 1'b0;
    end else begin
      if (abort) begin
        active <= 1'b0;
      end else if (start) begin
        active    <= lenProd != '0;
        dirQ      <= dirWrite;
        bytesLeft <= lenProd;
      end else if (txFire | rxFire) begin
        bytesLeft <= bytesLeft - LEFT_W'(1);
        if (lastByte) active <= 1'b0;
      end

      if (cpuTxWr) txReq <= 1'b0;
      else if (active & dirQ & owe & (txCount == '0)) txReq <= 1'b1;

      if (rxFire) rxReq <= 1'b1;
      else if (cpuRxRd) rxReq <= 1'b0;

      if (finishNow) begin
        statDataDone <= 1'b1;
        statProgDone <= finishDir | (statProgDone & ~begin_);
      end else if (begin_) begin
        statDataDone <= 1'b0;
        statProgDone <= 1'b0;
      end

      if (finishNow) irqDataDone <= 1'b1;
      else if (irqAck[0]) irqDataDone <= 1'b0;
      if (finishNow & finishDir) irqProgDone <= 1'b1;
      else if (irqAck[1]) irqProgDone <= 1'b0;
    end
  end

  assert_one_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((txFire || rxFire) && !abort && !start) |=> bytesLeft == $past(bytesLeft) - LEFT_W'(1));
  assert_quiet_abort_R11: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!active && statDataDone == $past(statDataDone)));
  assert_done_on_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(active) && !$past(abort)) |-> statDataDone);
  assert_txreq_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    cpuTxWr |=> !txReq);
endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine
  import cfe_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int BUS_BYTES = 4,
  parameter int LEN_W     = 12,
  parameter int CNT_W     = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic                          abort,
  input  logic                          dirWrite,
  input  logic [LEN_W-1:0]              blkLen,
  input  logic [CNT_W-1:0]              blkCnt,
  input  logic                          cpuTxWr,
  input  logic [8*BUS_BYTES-1:0]        cpuTxData,
  input  logic                          cpuRxRd,
  input  logic [$clog2(BUS_BYTES+1)-1:0] cpuBytes,
  output logic [8*BUS_BYTES-1:0]        cpuRxData,
  input  logic                          partWr,
  input  logic [31:0]                   partData,
  input  logic [1:0]                    irqAck,
  output logic [7:0]                    txByte,
  output logic                          txValid,
  input  logic                          txReady,
  input  logic [7:0]                    rxByte,
  input  logic                          rxValid,
  output logic                          rxReady,
  output logic                          active,
  output logic [LEN_W+CNT_W-1:0]        bytesLeft,
  output logic [$clog2(DEPTH):0]        txLevel,
  output logic [$clog2(DEPTH):0]        rxLevel,
  output logic                          txReq,
  output logic                          rxReq,
  output logic                          statDataDone,
  output logic                          statProgDone,
  output logic                          irqDataDone,
  output logic                          irqProgDone
);
  cfeStrobe_t st;
  logic flushReq;
  logic unusedPartBits;

  assign flushReq       = partWr & partData[0];
  assign unusedPartBits = ^partData[31:1];

  cfe_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort), .dirWrite(dirWrite),
    .blkLen(blkLen), .blkCnt(blkCnt), .cpuTxWr(cpuTxWr), .cpuRxRd(cpuRxRd),
    .irqAck(irqAck), .txReady(txReady), .rxValid(rxValid),
    .txCount(txLevel), .rxCount(rxLevel), .st(st),
    .txValid(txValid), .rxReady(rxReady), .active(active), .bytesLeft(bytesLeft),
    .txReq(txReq), .rxReq(rxReq), .statDataDone(statDataDone),
    .statProgDone(statProgDone), .irqDataDone(irqDataDone), .irqProgDone(irqProgDone)
  );

  cfe_datapath #(.DEPTH(DEPTH), .BUS_BYTES(BUS_BYTES)) uData (
    .clk(clk), .rstN(rstN), .st(st), .flushReq(flushReq),
    .cpuTxWr(cpuTxWr), .cpuTxData(cpuTxData), .cpuRxRd(cpuRxRd),
    .cpuBytes(cpuBytes), .rxByte(rxByte), .cpuRxData(cpuRxData),
    .txHead(txByte), .txCount(txLevel), .rxCount(rxLevel)
  );
endmodule

// File: tb/sim_card_fifo_engine.sv
`timescale 1ns/1ps
module sim_card_fifo_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 0, abort = 0, dirWrite = 0;
  logic [11:0] blkLen = '0;
  logic [15:0] blkCnt = '0;
  logic cpuTxWr = 0, cpuRxRd = 0, partWr = 0;
  logic [31:0] cpuTxData = '0, partData = '0;
  logic [2:0] cpuBytes = '0;
  logic [1:0] irqAck = '0;
  logic txReady = 0, rxValid = 0;
  logic [7:0] rxByte = '0;
  logic [31:0] cpuRxData;
  logic [7:0] txByte;
  logic txValid, rxReady, active, txReq, rxReq;
  logic statDataDone, statProgDone, irqDataDone, irqProgDone;
  logic [27:0] bytesLeft;
  logic [5:0] txLevel, rxLevel;

  int checks = 0, errors = 0, cyc = 0;
  bit cardOn = 0, finished = 0;

  // reference model state
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  int mLeft = 0;
  bit mActive = 0, mDirW = 0, mTxReq = 0, mRxReq = 0;
  bit mStatD = 0, mStatP = 0, mIrqD = 0, mIrqP = 0;
  logic [31:0] mRd = '0;

  card_fifo_engine u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finishRun(bit mFinishDir);
    mActive = 0; mStatD = 1; mIrqD = 1;
    if (mFinishDir) begin mStatP = 1; mIrqP = 1; end
  endtask

  // cycle model
  always @(posedge clk) begin
    if (!rstN) begin
      txQ.delete(); rxQ.delete();
      mLeft = 0; mActive = 0; mDirW = 0; mTxReq = 0; mRxReq = 0;
      mStatD = 0; mStatP = 0; mIrqD = 0; mIrqP = 0; mRd = '0;
    end else begin
      int n, preTx, preRx;
      bit txF, rxF;
      logic [31:0] w;
      n = (cpuBytes > 4) ? 4 : int'(cpuBytes);
      preTx = txQ.size(); preRx = rxQ.size();
      txF = mActive && mDirW && mLeft > 0 && preTx > 0 && txReady;
      rxF = mActive && !mDirW && mLeft > 0 && preRx < 32 && rxValid;
      if (cpuTxWr) mTxReq = 0;
      else if (mActive && mDirW && mLeft > 0 && preTx == 0) mTxReq = 1;
      if (rxF) mRxReq = 1; else if (cpuRxRd) mRxReq = 0;
      if (cpuRxRd) begin
        w = '0;
        for (int i = 0; i < n; i++)
          if (rxQ.size() > 0) w[8*(n-1-i) +: 8] = rxQ.pop_front();
        mRd = w;
      end
      if (rxF) rxQ.push_back(rxByte);
      if (txF) void'(txQ.pop_front());
      if (cpuTxWr)
        for (int i = 0; i < n; i++)
          if (i < 32 - preTx) txQ.push_back(cpuTxData[8*(n-1-i) +: 8]);
      if (partWr && partData[0]) txQ.delete();
      if (irqAck[0]) mIrqD = 0;
      if (irqAck[1]) mIrqP = 0;
      if (abort) mActive = 0;
      else if (start) begin
        txQ.delete(); rxQ.delete();
        mDirW = dirWrite; mLeft = int'(blkLen) * int'(blkCnt);
        mStatD = 0; mStatP = 0;
        if (mLeft == 0) finishRun(dirWrite); else mActive = 1;
      end else if (txF || rxF) begin
        mLeft--;
        if (mLeft == 0) finishRun(mDirW);
      end
    end
  end

  // compare every clock, after the edge has settled
  always @(posedge clk) begin
    #5;
    if (rstN) begin
      bit eTxV, eRxR;
      eTxV = mActive && mDirW && mLeft > 0 && txQ.size() > 0;
      eRxR = mActive && !mDirW && mLeft > 0 && rxQ.size() < 32;
      chk("R2 active", 32'(active), 32'(mActive));
      chk("R7 bytesLeft", 32'(bytesLeft), 32'(mLeft));
      chk("R1 txLevel", 32'(txLevel), 32'(txQ.size()));
      chk("R1 rxLevel", 32'(rxLevel), 32'(rxQ.size()));
      chk("R5 txReq", 32'(txReq), 32'(mTxReq));
      chk("R6 rxReq", 32'(rxReq), 32'(mRxReq));
      chk("R9 statDataDone", 32'(statDataDone), 32'(mStatD));
      chk("R9 statProgDone", 32'(statProgDone), 32'(mStatP));
      chk("R12 irqDataDone", 32'(irqDataDone), 32'(mIrqD));
      chk("R12 irqProgDone", 32'(irqProgDone), 32'(mIrqP));
      chk("R7 txValid", 32'(txValid), 32'(eTxV));
      chk("R8 rxReady", 32'(rxReady), 32'(eRxR));
      if (eTxV) chk("R3 txByte", 32'(txByte), 32'(txQ[0]));
      chk("R4 cpuRxData", cpuRxData, mRd);
    end
  end

  // card side stimulus
  always @(negedge clk) begin
    cyc++;
    txReady <= cardOn && (cyc % 3 != 0);
    rxValid <= cardOn && (cyc % 4 != 1);
    rxByte  <= 8'(cyc * 7 + 3);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doStart(bit dir, int len, int cnt);
    dirWrite = dir; blkLen = 12'(len); blkCnt = 16'(cnt); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic doTx(int n, logic [31:0] d);
    cpuBytes = 3'(n); cpuTxData = d; cpuTxWr = 1;
    @(negedge clk); cpuTxWr = 0;
  endtask

  task automatic doRx(int n);
    cpuBytes = 3'(n); cpuRxRd = 1;
    @(negedge clk); cpuRxRd = 0;
  endtask

  task automatic doPart(logic [31:0] d);
    partData = d; partWr = 1;
    @(negedge clk); partWr = 0;
  endtask

  task automatic waitIdle();
    for (int g = 0; g < 3000 && mActive; g++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R13 reset state
    chk("R13 active", 32'(active), 0);
    chk("R13 bytesLeft", 32'(bytesLeft), 0);
    chk("R13 levels", 32'({txLevel, rxLevel}), 0);
    chk("R13 flags", 32'({txReq, rxReq, statDataDone, statProgDone, irqDataDone, irqProgDone}), 0);
    chk("R13 cpuRxData", cpuRxData, 0);
    rstN = 1;
    idle(2);

    // write transfer of 12 bytes, mixed access sizes (R3 R5 R7 R9)
    doStart(1, 6, 2);
    idle(2);
    chk("R5 txReq raised on empty ring", 32'(txReq), 1);
    doTx(4, 32'hA1B2C3D4);
    chk("R5 txReq cleared by write", 32'(txReq), 0);
    doTx(2, 32'h0000E5F6);
    doTx(1, 32'h00000077);
    chk("R3 first byte from top lane", 32'(txByte), 32'hA1);
    cardOn = 1;
    idle(12);
    doTx(4, 32'h11223344);
    doTx(1, 32'h00000055);
    waitIdle();
    idle(2);
    chk("R9 write done data", 32'(statDataDone), 1);
    chk("R9 write done prog", 32'(statProgDone), 1);

    // overflow and partial-buffer flush while idle (R1 R10)
    cardOn = 0;
    for (int k = 0; k < 9; k++) doTx(4, 32'h01020304 + 32'(k) * 32'h10101010);
    chk("R1 tx ring capped at 32", 32'(txLevel), 32);
    doPart(32'h0000_0002);
    chk("R10 bit0 clear keeps ring", 32'(txLevel), 32);
    doPart(32'h0000_0001);
    chk("R10 flush empties ring", 32'(txLevel), 0);

    // read transfer of 40 bytes, ring fills (R4 R6 R8)
    cardOn = 1;
    doStart(0, 40, 1);
    idle(80);
    chk("R8 rx ring full", 32'(rxLevel), 32);
    chk("R8 rxReady low when full", 32'(rxReady), 0);
    for (int k = 0; k < 400 && (mActive || rxQ.size() > 0); k++) begin
      doRx((k % 3 == 0) ? 4 : ((k % 3 == 1) ? 2 : 1));
      idle(1);
    end
    doRx(4);
    chk("R4 read from empty ring gives zero", cpuRxData, 0);
    chk("R9 read done prog stays clear", 32'(statProgDone), 0);

    // acknowledge (R12)
    irqAck = 2'b01; @(negedge clk); irqAck = 2'b00;
    chk("R12 data irq cleared", 32'(irqDataDone), 0);
    chk("R12 prog irq kept", 32'(irqProgDone), 1);
    irqAck = 2'b10; @(negedge clk); irqAck = 2'b00;
    chk("R12 prog irq cleared", 32'(irqProgDone), 0);

    // abort (R11)
    cardOn = 0;
    doStart(1, 1, 100);
    doTx(4, 32'hDEADBEEF);
    cardOn = 1;
    idle(2);
    abort = 1; @(negedge clk); abort = 0;
    chk("R11 inactive after abort", 32'(active), 0);
    chk("R11 no data done", 32'(statDataDone), 0);
    idle(4);
    chk("R11 no handshake after abort", 32'(txValid), 0);

    // zero-length start (R9)
    doStart(0, 0, 5);
    chk("R9 zero length completes", 32'(statDataDone), 1);
    chk("R9 zero length inactive", 32'(active), 0);

    // short read with back-to-back reads
    doStart(0, 8, 1);
    for (int k = 0; k < 12; k++) doRx(2);
    waitIdle();
    idle(3);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule